// File: doc/BRIEF.md
# Effective Address and Cycle Calculator

This block serves the address stage of an 8-bit processor core. For each indexed or indirect operand form, and for relative branches, it works out the effective operand address, the address of the next instruction and the number of clock cycles the instruction costs. The decoder supplies the addressing form, the operand bytes, both index registers, the current program counter and the branch condition. The block then answers with a one-cycle `done` strobe and the three results.

The direct forms need no memory traffic. They are computed at the edge that accepts `start` and are presented one cycle later. The two indirect forms read a 16-bit pointer from page zero through a small synchronous read port, one byte per cycle. Their results follow four cycles after `start`. The cycle counts depend on the data. Indexed absolute access and taken branches gain a cycle when they move into another 256-byte page. Zero-page indexing and zero-page pointer reads never leave page zero.

Top module: `addr_cycle_unit`

## Requirements
- R1: Zero-page indexed form (`mode` 0 uses X, `mode` 1 uses Y): the address is `{8'h00, (opnd_lo + index) mod 256}`, the next PC is PC+2 and the cost is 4 cycles.
- R2: Absolute indexed form (`mode` 2 uses X, `mode` 3 uses Y): the base is `{opnd_hi, opnd_lo}`, the address is (base + index) mod 65536, the next PC is PC+3 and the cost is 4 cycles when no page is crossed.
- R3: In the absolute indexed form, when `opnd_lo` + index is 256 or more, the cost is 5 cycles. This includes the case where the address wraps from 0xFFFF to page 0.
- R4: Pre-indexed indirect form (`mode` 4): the pointer is read at (`opnd_lo` + X) mod 256, the address is that 16-bit pointer (low byte first), the next PC is PC+2 and the cost is 6 cycles.
- R5: Post-indexed indirect form (`mode` 5): the pointer is read at `opnd_lo`, the address is (pointer + Y) mod 65536, the next PC is PC+2 and the cost is always 5 cycles.
- R6: A pointer read issues exactly two reads: the low byte at address p, then the high byte at (p+1) mod 256. Read data arrives the cycle after the address.
- R7: Branch form (`mode` 6, and also `mode` 7) with `br_take` low: the next PC is PC+2 and the cost is 2 cycles. `eff_addr` still shows the branch target.
- R8: Branch form with `br_take` high: the target is PC + 2 + sign-extended `opnd_lo`, and the next PC is that target. The cost is 3 cycles, or 4 when the target's high byte differs from the high byte of `pc_cur`.
- R9: `done` is high for a single cycle. For direct forms it comes 1 clock edge after the edge that samples `start`; for indirect forms it comes 4 edges after. `start` and all operand inputs are ignored while a pointer read is in progress.
- R10: After reset, `done` and `zp_rd_en` are low and `eff_addr`, `next_pc` and `cyc_cnt` are zero.
- R11: `zp_rd_en` is asserted only for the two indirect forms, never for direct or branch forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation with the current inputs |
| mode | input | 3 | Addressing form select (0..7) |
| opnd_lo | input | 8 | First operand byte (zero-page address, low address byte or branch offset) |
| opnd_hi | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc_cur | input | 16 | Address of the instruction being processed |
| br_take | input | 1 | Branch condition is true |
| zp_rd_en | output | 1 | Zero-page read request |
| zp_rd_addr | output | 8 | Zero-page read address |
| zp_rd_data | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle result strobe |
| eff_addr | output | 16 | Effective address, or branch target |
| next_pc | output | 16 | Address of the following instruction |
| cyc_cnt | output | 3 | Instruction cycle cost |

## Verification
Some properties are checked on every cycle by the assertions. Zero-page indexed results must stay in page zero. Absolute indexed costs must be 4 or 5 cycles, with PC+3. A branch that is not taken must cost 2 cycles and advance PC by 2. Reads may only be issued for indirect forms. The second pointer read must target the byte after the first, modulo 256. `done` must never rise while a read is in progress. The bench scenarios cover the rest: the exact summed addresses, the page-crossing penalties for absolute and branch forms, the pointer wrap at 0xFF, the wrap from 0xFFFF to 0x0000, the result latency per form, and the fact that `start` is ignored while the unit is busy.

// File: rtl/addr_cycle_unit.sv
module addr_cycle_unit #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] pc_cur,
  input  logic          br_take,
  output logic          zp_rd_en,
  output logic [DW-1:0] zp_rd_addr,
  input  logic [DW-1:0] zp_rd_data,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] next_pc,
  output logic [CW-1:0] cyc_cnt
);

  localparam logic [2:0] M_ZPX  = 3'd0;
  localparam logic [2:0] M_ZPY  = 3'd1;
  localparam logic [2:0] M_ABSX = 3'd2;
  localparam logic [2:0] M_ABSY = 3'd3;
  localparam logic [2:0] M_INDX = 3'd4;
  localparam logic [2:0] M_INDY = 3'd5;
  localparam int         HW     = AW - DW;

  typedef enum logic [1:0] {S_IDLE, S_RDLO, S_RDHI, S_FIN} st_t;
  st_t st;

  logic [2:0]    m_q;
  logic [DW-1:0] base_q, yv_q, plo_q;
  logic [AW-1:0] pc_q;
  logic          br_q;

  // live decode of the inputs for the forms resolved at start
  wire            use_y    = (mode == M_ZPY) || (mode == M_ABSY);
  wire [DW-1:0]   idx      = use_y ? idx_y : idx_x;
  wire [DW-1:0]   zp_sum   = opnd_lo + idx;
  wire [AW-1:0]   abs_sum  = {opnd_hi, opnd_lo} + AW'(idx);
  wire [DW:0]     lo_sum   = {1'b0, opnd_lo} + {1'b0, idx};
  wire            abs_pgx  = lo_sum[DW];
  wire [AW-1:0]   pc_p2    = pc_cur + AW'(2);
  wire [AW-1:0]   pc_p3    = pc_cur + AW'(3);
  wire [AW-1:0]   br_off   = {{HW{opnd_lo[DW-1]}}, opnd_lo};
  wire [AW-1:0]   br_tgt   = pc_p2 + br_off;
  wire            br_pgx   = br_tgt[AW-1:DW] != pc_cur[AW-1:DW];
  wire [DW-1:0]   ptr_at   = (mode == M_INDX) ? zp_sum : opnd_lo;
  wire [AW-1:0]   ptr_full = {zp_rd_data, plo_q};

  assign zp_rd_en   = (st == S_RDLO) || (st == S_RDHI);
  assign zp_rd_addr = (st == S_RDHI) ? base_q + DW'(1) : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      m_q      <= '0;
      base_q   <= '0;
      yv_q     <= '0;
      plo_q    <= '0;
      pc_q     <= '0;
      br_q     <= 1'b0;
      done     <= 1'b0;
      eff_addr <= '0;
      next_pc  <= '0;
      cyc_cnt  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_q    <= mode;
          pc_q   <= pc_cur;
          br_q   <= br_take;
          yv_q   <= idx_y;
          base_q <= ptr_at;
          case (mode)
            M_ZPX, M_ZPY: begin
              eff_addr <= {{HW{1'b0}}, zp_sum};
              next_pc  <= pc_p2;
              cyc_cnt  <= CW'(4);
              done     <= 1'b1;
            end
            M_ABSX, M_ABSY: begin
              eff_addr <= abs_sum;
              next_pc  <= pc_p3;
              cyc_cnt  <= abs_pgx ? CW'(5) : CW'(4);
              done     <= 1'b1;
            end
            M_INDX, M_INDY: st <= S_RDLO;
            default: begin
              eff_addr <= br_tgt;
              next_pc  <= br_take ? br_tgt : pc_p2;
              cyc_cnt  <= !br_take ? CW'(2) : (br_pgx ? CW'(4) : CW'(3));
              done     <= 1'b1;
            end
          endcase
        end
        S_RDLO: st <= S_RDHI;
        S_RDHI: begin
          plo_q <= zp_rd_data;
          st    <= S_FIN;
        end
        default: begin
          eff_addr <= (m_q == M_INDX) ? ptr_full : ptr_full + AW'(yv_q);
          next_pc  <= pc_q + AW'(2);
          cyc_cnt  <= (m_q == M_INDX) ? CW'(6) : CW'(5);
          done     <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end

  AST_ZP_IN_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    done && (m_q == M_ZPX || m_q == M_ZPY) |-> eff_addr[AW-1:DW] == '0 && cyc_cnt == CW'(4)); // R1
  AST_ABS_COST: assert property (@(posedge clk) disable iff (!rst_n)
    done && (m_q == M_ABSX || m_q == M_ABSY) |-> (cyc_cnt == CW'(4) || cyc_cnt == CW'(5)) && next_pc == pc_q + AW'(3)); // R2
  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    done && m_q[2:1] == 2'b11 && !br_q |-> cyc_cnt == CW'(2) && next_pc == pc_q + AW'(2)); // R7
  AST_RD_ONLY_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    zp_rd_en |-> (m_q == M_INDX || m_q == M_INDY)); // R11
  AST_PTR_HI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    zp_rd_en && $past(zp_rd_en) |-> zp_rd_addr == DW'($past(zp_rd_addr) + DW'(1))); // R6
  AST_NO_DONE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    zp_rd_en |=> !done); // R9
  AST_FIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zp_rd_en) |=> done); // R9

endmodule

// File: tb/tb_addr_cycle_unit.sv
`timescale 1ns/1ps
module tb_addr_cycle_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc_cur = '0;
  logic        br_take = 1'b0;
  logic        zp_rd_en;
  logic [7:0]  zp_rd_addr;
  logic [7:0]  zp_rd_data = '0;
  logic        done;
  logic [15:0] eff_addr, next_pc;
  logic [2:0]  cyc_cnt;

  int checks = 0, errors = 0, edge_cnt = 0, rd_count = 0;
  logic [7:0] zmem [256];

  logic [15:0] q_eff[$], q_npc[$];
  logic [2:0]  q_cyc[$];
  int          q_lat[$], q_rds[$], q_sedge[$], q_rbase[$];
  string       q_req[$];

  always #2.5 clk = ~clk;

  addr_cycle_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y), .pc_cur(pc_cur),
    .br_take(br_take), .zp_rd_en(zp_rd_en), .zp_rd_addr(zp_rd_addr),
    .zp_rd_data(zp_rd_data), .done(done), .eff_addr(eff_addr),
    .next_pc(next_pc), .cyc_cnt(cyc_cnt)
  );

  always @(posedge clk) begin
    edge_cnt <= edge_cnt + 1;
    if (zp_rd_en) begin
      zp_rd_data <= zmem[zp_rd_addr];
      rd_count   <= rd_count + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each result strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_eff.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected done actual 1 expected 0");
      end else begin
        string r;
        r = q_req.pop_front();
        chk(r, "eff_addr", eff_addr, q_eff.pop_front());
        chk(r, "next_pc", next_pc, q_npc.pop_front());
        chk(r, "cyc_cnt", cyc_cnt, q_cyc.pop_front());
        chk({r, "/R9"}, "latency", edge_cnt - q_sedge.pop_front(), q_lat.pop_front());
        chk({r, "/R11"}, "reads", rd_count - q_rbase.pop_front(), q_rds.pop_front());
      end
    end
  end

  // driver: computes the expected result from the requirements and launches
  task automatic run_op(input logic [2:0] md, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] xv, input logic [7:0] yv, input logic [15:0] pc,
                        input logic br, input string req, input int hold);
    logic [15:0] e, n, t;
    logic [2:0]  c;
    logic [7:0]  idx, s, p, p1;
    logic [8:0]  ls;
    int lat, rds, tmo;
    lat = 1; rds = 0; n = pc + 16'd2;
    idx = (md == 3'd1 || md == 3'd3) ? yv : xv;
    case (md)
      3'd0, 3'd1: begin s = lo + idx; e = {8'h00, s}; c = 3'd4; end
      3'd2, 3'd3: begin
        e = {hi, lo} + {8'h00, idx}; ls = {1'b0, lo} + {1'b0, idx};
        c = ls[8] ? 3'd5 : 3'd4; n = pc + 16'd3;
      end
      3'd4, 3'd5: begin
        p = (md == 3'd4) ? lo + xv : lo; p1 = p + 8'd1;
        e = {zmem[p1], zmem[p]};
        if (md == 3'd5) e = e + {8'h00, yv};
        c = (md == 3'd4) ? 3'd6 : 3'd5; lat = 4; rds = 2;
      end
      default: begin
        t = pc + 16'd2 + {{8{lo[7]}}, lo}; e = t;
        if (br) begin n = t; c = (t[15:8] != pc[15:8]) ? 3'd4 : 3'd3; end
        else c = 3'd2;
      end
    endcase
    @(negedge clk);
    mode = md; opnd_lo = lo; opnd_hi = hi; idx_x = xv; idx_y = yv; pc_cur = pc; br_take = br;
    start = 1'b1;
    q_eff.push_back(e); q_npc.push_back(n); q_cyc.push_back(c); q_lat.push_back(lat);
    q_rds.push_back(rds); q_sedge.push_back(edge_cnt); q_rbase.push_back(rd_count);
    q_req.push_back(req);
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      mode = 3'd2; opnd_lo = ~lo; idx_x = ~xv; idx_y = ~yv; pc_cur = ~pc;
    end
    @(negedge clk);
    start = 1'b0;
    tmo = 0;
    while (q_eff.size() != 0 && tmo < 50) begin @(negedge clk); tmo++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) zmem[i] = 8'(i * 91) ^ 8'hA7;
    zmem[8'h40] = 8'hF8; zmem[8'h41] = 8'hFF;
    zmem[8'hFF] = 8'h34; zmem[8'h00] = 8'h12;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done", done, 0);
    chk("R10", "zp_rd_en", zp_rd_en, 0);
    chk("R10", "eff_addr", eff_addr, 0);
    chk("R10", "next_pc", next_pc, 0);
    chk("R10", "cyc_cnt", cyc_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(3'd0, 8'h80, 8'h00, 8'h05, 8'h00, 16'h0200, 1'b0, "R1", 1);
    run_op(3'd0, 8'hF0, 8'h00, 8'h20, 8'h00, 16'hFFFF, 1'b0, "R1", 1);
    run_op(3'd1, 8'hFF, 8'h00, 8'h33, 8'h01, 16'h0300, 1'b0, "R1", 1);
    run_op(3'd2, 8'h34, 8'h12, 8'h10, 8'h00, 16'h0400, 1'b0, "R2", 1);
    run_op(3'd3, 8'hF0, 8'h12, 8'h00, 8'h10, 16'h0500, 1'b0, "R3", 1);
    run_op(3'd2, 8'hFF, 8'hFF, 8'h01, 8'h00, 16'hFFFE, 1'b0, "R3", 1);
    run_op(3'd3, 8'h00, 8'h20, 8'h00, 8'hFF, 16'h0600, 1'b0, "R2", 1);
    run_op(3'd4, 8'h10, 8'h00, 8'h04, 8'h00, 16'h0700, 1'b0, "R4", 1);
    run_op(3'd4, 8'hFE, 8'h00, 8'h01, 8'h00, 16'h0800, 1'b0, "R6", 1);
    run_op(3'd4, 8'hC0, 8'h00, 8'h50, 8'h00, 16'h0900, 1'b0, "R4", 1);
    run_op(3'd5, 8'h22, 8'h00, 8'h00, 8'h10, 16'h0A00, 1'b0, "R5", 1);
    run_op(3'd5, 8'h40, 8'h00, 8'h00, 8'h10, 16'h0B00, 1'b0, "R5", 1);
    run_op(3'd5, 8'hFF, 8'h00, 8'h00, 8'h01, 16'h0C00, 1'b0, "R6", 1);
    run_op(3'd6, 8'h10, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b0, "R7", 1);
    run_op(3'd6, 8'h10, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b1, "R8", 1);
    run_op(3'd6, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b1, "R8", 1);
    run_op(3'd6, 8'h00, 8'h00, 8'h00, 8'h00, 16'h10FE, 1'b1, "R8", 1);
    run_op(3'd7, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b1, "R8", 1);
    run_op(3'd7, 8'h80, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b0, "R7", 1);
    // R9 start held while busy: one result, garbage inputs ignored
    run_op(3'd4, 8'h30, 8'h00, 8'h02, 8'h00, 16'h3000, 1'b0, "R9", 3);
    run_op(3'd5, 8'h31, 8'h00, 8'h00, 8'h80, 16'h3100, 1'b0, "R9", 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule